// File: doc/BRIEF.md
# Masked Dual I2C Slave Address Filter

This block decides whether an I2C slave responds to the address byte just received. The slave can answer either one 7-bit address or two. Matching runs in two stages. The coarse stage compares the received address against the primary address under a don't-care mask. In two-address mode that mask ignores every bit position where the primary and secondary addresses differ. A coarse hit produces a match pulse, and also a wake pulse when wake is enabled. The exact stage then decides ACK or NAK and reports which configured address was hit.

Because the coarse stage ignores n differing bits, it accepts 2^n addresses. The extra ones are aliases. An alias still raises the coarse match and the wake pulse so that a sleeping device powers up. The exact stage then NAKs it. A bit-level receiver in front of this block supplies the captured address byte and a START indication. The side that handles data uses the held `addr1_active` and `rw` outputs to pick a buffer and a transfer direction.

Top module: `i2c_dual_addr_filter`

## Requirements
- R1: After reset, `coarse_match`, `wake`, `ack`, `addr1_active` and `rw` are all 0.
- R2: When `cfg_two_addr` = 0, the mask treats all seven bits as significant. Only the primary address gives a coarse match and an ACK. The secondary address gives neither.
- R3: When `cfg_two_addr` = 1 and the two addresses differ in one bit (for example 0x24 and 0x34), exactly those two addresses out of all 128 give a coarse match.
- R4: When `cfg_two_addr` = 1 and the two addresses differ in n bits, exactly 2^n addresses give a coarse match. For 0x24 and 0x30 these are 0x20, 0x24, 0x30 and 0x34.
- R5: `ack` is 1 only when the received address equals the primary address, or equals the secondary address in two-address mode. Coarse-only aliases such as 0x20 and 0x34 (with 0x24 and 0x30 configured) get `ack` = 0.
- R6: `wake` pulses together with every coarse match, aliases included, when `cfg_wake_en` = 1. It stays 0 when `cfg_wake_en` = 0.
- R7: The general-call address (7-bit 0x00) never gives a coarse match, wake or ACK, even when the mask would let it alias.
- R8: In the address byte, bits 7:1 are the 7-bit address and bit 0 is the R/W bit. `rw` takes bit 0 of each received byte and holds it until the next START.
- R9: `addr1_active` is set by an exact hit on the primary address. It is cleared by any other address byte and by `start_det`. Otherwise it holds its value.
- R10: `coarse_match`, `wake` and `ack` are one-cycle pulses in the clock cycle after the cycle in which `addr_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr1 | input | 7 | Primary 7-bit address, right-justified |
| cfg_addr2 | input | 7 | Secondary 7-bit address, right-justified |
| cfg_two_addr | input | 1 | 1 = answer both addresses, 0 = primary only |
| cfg_wake_en | input | 1 | Enables the wake pulse on a coarse match |
| start_det | input | 1 | START or repeated START seen on the bus |
| addr_valid | input | 1 | Pulse: `addr_byte` holds a completed address byte |
| addr_byte | input | 8 | Received byte: address in 7:1, R/W in 0 |
| coarse_match | output | 1 | Pulse: address passed the masked compare |
| wake | output | 1 | Pulse: coarse match with wake enabled |
| ack | output | 1 | Pulse: exact hit, the slave should ACK |
| addr1_active | output | 1 | Last accepted address was the primary one |
| rw | output | 1 | R/W bit of the last address byte |

## Verification
The hardest case to reach from the ports is an alias: an address that passes the coarse stage but fails the exact stage. It needs a configuration whose two addresses differ in more than one bit, and an address byte that mixes bits from both. The stimulus configures pairs that differ in one bit and in two bits, then sweeps all 128 addresses. The number of coarse hits and ACKs across the sweep must match the number expected for each pair. A further configuration chooses two addresses whose mask lets 0x00 alias, to show that the general-call exclusion overrides the mask.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;
    localparam int ADDR_W = 7;
    localparam int BYTE_W = ADDR_W + 1;

    typedef struct packed {
        logic coarse;
        logic wake;
        logic ack;
        logic a1_act;
        logic rw;
    } filt_state_t;
endpackage

// File: rtl/i2c_mask_gen.sv
module i2c_mask_gen #(
    parameter int W = 7
) (
    input  logic [W-1:0] addr_a,
    input  logic [W-1:0] addr_b,
    input  logic         two_mode,
    output logic [W-1:0] care
);
    // A bit is significant unless two-address mode is on and the addresses differ there
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign care[i] = ~(two_mode & (addr_a[i] ^ addr_b[i]));
    end
endmodule

// File: rtl/i2c_addr_cmp.sv
module i2c_addr_cmp #(
    parameter int W = 7
) (
    input  logic [W-1:0] rx_addr,
    input  logic [W-1:0] addr_a,
    input  logic [W-1:0] addr_b,
    input  logic [W-1:0] care,
    input  logic         two_mode,
    output logic         coarse_hit,
    output logic         hit_a,
    output logic         hit_b
);
    logic not_gc;
    assign not_gc     = |rx_addr;
    assign coarse_hit = not_gc && (((rx_addr ^ addr_a) & care) == '0);
    assign hit_a      = not_gc && (rx_addr == addr_a);
    assign hit_b      = not_gc && two_mode && (rx_addr == addr_b);
endmodule

// File: rtl/i2c_dual_addr_filter.sv
module i2c_dual_addr_filter
    import i2c_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr1,
    input  logic [ADDR_W-1:0] cfg_addr2,
    input  logic              cfg_two_addr,
    input  logic              cfg_wake_en,
    input  logic              start_det,
    input  logic              addr_valid,
    input  logic [BYTE_W-1:0] addr_byte,
    output logic              coarse_match,
    output logic              wake,
    output logic              ack,
    output logic              addr1_active,
    output logic              rw
);
    logic [ADDR_W-1:0] care;
    logic [ADDR_W-1:0] rx_addr;
    logic              coarse_hit, hit_a, hit_b;
    filt_state_t       st_d, st_q;

    assign rx_addr = addr_byte[BYTE_W-1:1];

    i2c_mask_gen #(.W(ADDR_W)) u_mask (
        .addr_a   (cfg_addr1),
        .addr_b   (cfg_addr2),
        .two_mode (cfg_two_addr),
        .care     (care)
    );

    i2c_addr_cmp #(.W(ADDR_W)) u_cmp (
        .rx_addr    (rx_addr),
        .addr_a     (cfg_addr1),
        .addr_b     (cfg_addr2),
        .care       (care),
        .two_mode   (cfg_two_addr),
        .coarse_hit (coarse_hit),
        .hit_a      (hit_a),
        .hit_b      (hit_b)
    );

    always_comb begin
        st_d        = st_q;
        st_d.coarse = 1'b0;
        st_d.wake   = 1'b0;
        st_d.ack    = 1'b0;
        if (start_det) begin
            st_d.a1_act = 1'b0;
            st_d.rw     = 1'b0;
        end
        if (addr_valid) begin
            st_d.coarse = coarse_hit;
            st_d.wake   = coarse_hit & cfg_wake_en;
            st_d.ack    = coarse_hit & (hit_a | hit_b);
            st_d.a1_act = coarse_hit & hit_a;
            st_d.rw     = addr_byte[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign coarse_match = st_q.coarse;
    assign wake         = st_q.wake;
    assign ack          = st_q.ack;
    assign addr1_active = st_q.a1_act;
    assign rw           = st_q.rw;

    AST_PULSE_FROM_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (coarse_match || ack) |-> $past(addr_valid)); // R10
    AST_ACK_NEEDS_COARSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> coarse_match); // R5
    AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (coarse_match && $past(cfg_wake_en))); // R6
    AST_GC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(addr_valid) && ($past(addr_byte[BYTE_W-1:1]) == '0)) |-> !coarse_match); // R7
    AST_A1_RISE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr1_active) |-> ack); // R9
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !addr_valid) |=> !addr1_active); // R9
    AST_SINGLE_NO_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !cfg_two_addr && (addr_byte[BYTE_W-1:1] != cfg_addr1)) |=> !ack); // R2
endmodule

// File: tb/tb_i2c_dual_addr_filter.sv
module tb_i2c_dual_addr_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] cfg_addr1 = 7'h24;
    logic [6:0] cfg_addr2 = 7'h34;
    logic       cfg_two_addr = 1'b0;
    logic       cfg_wake_en = 1'b0;
    logic       start_det = 1'b0;
    logic       addr_valid = 1'b0;
    logic [7:0] addr_byte = 8'h00;
    logic       coarse_match, wake, ack, addr1_active, rw;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    i2c_dual_addr_filter dut (
        .clk(clk), .rst_n(rst_n), .cfg_addr1(cfg_addr1), .cfg_addr2(cfg_addr2),
        .cfg_two_addr(cfg_two_addr), .cfg_wake_en(cfg_wake_en), .start_det(start_det),
        .addr_valid(addr_valid), .addr_byte(addr_byte), .coarse_match(coarse_match),
        .wake(wake), .ack(ack), .addr1_active(addr1_active), .rw(rw)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Present one address byte; outputs are sampled on the negedge after the capturing edge
    task automatic send(input logic [6:0] a, input logic rwb,
                        output logic cm, output logic wk, output logic ak);
        @(negedge clk);
        addr_byte  = {a, rwb};
        addr_valid = 1'b1;
        @(negedge clk);
        addr_valid = 1'b0;
        cm = coarse_match; wk = wake; ak = ack;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_det = 1'b1;
        @(negedge clk);
        start_det = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "coarse_match", coarse_match, 1'b0);
        chk("R1", "wake", wake, 1'b0);
        chk("R1", "ack", ack, 1'b0);
        chk("R1", "addr1_active", addr1_active, 1'b0);
        chk("R1", "rw", rw, 1'b0);
    endtask

    task automatic t_single();
        logic cm, wk, ak;
        cfg_two_addr = 1'b0; cfg_addr1 = 7'h24; cfg_addr2 = 7'h34;
        send(7'h24, 1'b0, cm, wk, ak);
        chk("R2", "primary coarse", cm, 1'b1);
        chk("R2", "primary ack", ak, 1'b1);
        send(7'h34, 1'b0, cm, wk, ak);
        chk("R2", "secondary coarse", cm, 1'b0);
        chk("R2", "secondary ack", ak, 1'b0);
    endtask

    task automatic sweep(input string req, input int exp_coarse, input int exp_ack);
        int nc = 0;
        int na = 0;
        for (int i = 0; i < 128; i++) begin
            logic cm, wk, ak;
            send(7'(i), 1'b0, cm, wk, ak);
            nc += int'(cm);
            na += int'(ak);
        end
        chk_int(req, "coarse count", nc, exp_coarse);
        chk_int("R5", "ack count", na, exp_ack);
    endtask

    task automatic t_one_bit();
        cfg_two_addr = 1'b1; cfg_addr1 = 7'h24; cfg_addr2 = 7'h34;
        sweep("R3", 2, 2);
    endtask

    task automatic t_two_bit();
        logic cm, wk, ak;
        cfg_two_addr = 1'b1; cfg_addr1 = 7'h24; cfg_addr2 = 7'h30; cfg_wake_en = 1'b1;
        sweep("R4", 4, 2);
        send(7'h20, 1'b0, cm, wk, ak);
        chk("R4", "0x20 coarse", cm, 1'b1);
        chk("R6", "0x20 wake", wk, 1'b1);
        chk("R5", "0x20 nak", ak, 1'b0);
        send(7'h34, 1'b0, cm, wk, ak);
        chk("R5", "0x34 nak", ak, 1'b0);
        send(7'h30, 1'b0, cm, wk, ak);
        chk("R5", "0x30 ack", ak, 1'b1);
        chk("R9", "secondary not addr1", addr1_active, 1'b0);
        send(7'h11, 1'b0, cm, wk, ak);
        chk("R6", "miss no wake", wk, 1'b0);
        cfg_wake_en = 1'b0;
        send(7'h20, 1'b0, cm, wk, ak);
        chk("R6", "wake disabled", wk, 1'b0);
        chk("R6", "coarse still", cm, 1'b1);
    endtask

    task automatic t_gc();
        logic cm, wk, ak;
        cfg_two_addr = 1'b1; cfg_addr1 = 7'h01; cfg_addr2 = 7'h02; cfg_wake_en = 1'b1;
        send(7'h00, 1'b0, cm, wk, ak);
        chk("R7", "gc coarse", cm, 1'b0);
        chk("R7", "gc wake", wk, 1'b0);
        chk("R7", "gc ack", ak, 1'b0);
        send(7'h03, 1'b0, cm, wk, ak);
        chk("R7", "alias 0x03 coarse", cm, 1'b1);
    endtask

    task automatic t_hold();
        logic cm, wk, ak;
        cfg_two_addr = 1'b1; cfg_addr1 = 7'h24; cfg_addr2 = 7'h30; cfg_wake_en = 1'b0;
        send(7'h24, 1'b1, cm, wk, ak);
        chk("R9", "addr1_active set", addr1_active, 1'b1);
        chk("R8", "rw read", rw, 1'b1);
        @(negedge clk);
        chk("R10", "coarse one cycle", coarse_match, 1'b0);
        chk("R10", "ack one cycle", ack, 1'b0);
        repeat (3) @(negedge clk);
        chk("R9", "addr1_active held", addr1_active, 1'b1);
        chk("R8", "rw held", rw, 1'b1);
        pulse_start();
        chk("R9", "start clears addr1_active", addr1_active, 1'b0);
        chk("R8", "start clears rw", rw, 1'b0);
        send(7'h24, 1'b0, cm, wk, ak);
        chk("R8", "rw write", rw, 1'b0);
        send(7'h55, 1'b1, cm, wk, ak);
        chk("R9", "miss clears addr1_active", addr1_active, 1'b0);
        chk("R8", "rw from miss byte", rw, 1'b1);
    endtask

    initial begin
        #1;
        t_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_single();
        t_one_bit();
        t_two_bit();
        t_gc();
        t_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule